// File: doc/BRIEF.md
# Reciprocal Frequency Meter Core

This block measures an unknown input frequency against its own clock, which serves as the reference. It counts input periods and reference cycles over one shared gate interval. The gate opens and closes on rising edges of the input, so the gate always spans a whole number of input periods. A host requests a measurement with a low-going pulse on `start_n`. It waits for `running` to rise and then to fall. It checks the two range flags, and only if both are clear does it read the two counts.

The frequency is obtained outside the block as `in_count * f_clk / (ref_count + 2**REF_W)`. The reference counter always runs past `2**REF_W` before the gate may close, so that high bit is implied and not output. Each counter is a chain of `SEG_W`-bit segments. All segments run on the one clock, and each segment's terminal count drives the count enable of the next segment. Both asynchronous inputs pass through two-flop synchronisers, and their edges are detected in the clock domain.

All pins are plain control and status levels. No data stream and no back-pressure exist at the boundary. The counts stay valid until the next start request.

Top module: `freqm_core`

## Requirements
- R1: After reset, `running`, `too_low` and `too_high` are 0, and both counts are 0.
- R2: A falling edge on `start_n` clears both counts and both flags, drives `running` low and arms the gate. While no rising input edge arrives, `running` stays 0 and the counts stay 0.
- R3: The first rising input edge after arming raises `running`. That edge is not counted, so the counts are still 0 when `running` rises.
- R4: While the gate is open, `in_count` grows by exactly one for each rising input edge, and never by more.
- R5: The gate closes on the first rising input edge seen while the reference count is already at least `2**REF_W`. That closing edge is counted. `running` falls, and both counts hold until the next start request.
- R6: `ref_count` carries the low `REF_W` bits of the reference cycles between the opening and closing edges. That number equals `in_count` times the input period in clock cycles.
- R7: If the reference count reaches `2**(REF_W+1) - 2` with no closing edge, then `too_low` is set and `running` falls. `ref_count` then reads `2**REF_W - 2`. The longest gate that is accepted is `2**(REF_W+1) - 2` cycles.
- R8: If `in_count` wraps past all ones while the gate is open, then `too_high` is set, `running` falls and `in_count` reads 0. The two flags are never both set.
- R9: A start request while the gate is open aborts the measurement. It clears the counts, drops `running` and arms the gate again.
- R10: The segmented reference chain counts without gaps. While the gate stays open, `ref_count` rises by exactly one every clock, including across segment boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Asynchronous measurement request, acts on its falling edge |
| sig_in | input | 1 | Asynchronous signal being measured |
| running | output | 1 | High while the gate is open |
| ref_count | output | REF_W | Low bits of the reference cycles counted in the gate |
| in_count | output | IN_W | Input periods counted in the gate |
| too_low | output | 1 | Input too slow: the gate limit was hit |
| too_high | output | 1 | Input too fast: the input counter overflowed |

## Verification
A dropped or early carry between segments shows up at once as a `ref_count` step that is not one while `running` is high. It also shows as a wrong close point or a wrong count at the end of the same gate. A wrong gate state appears as `running` rising without an edge, or staying high past the limit. A wrong flag condition gives a flag with the wrong count beside it, in the cycle where `running` falls. Stale counter contents show as nonzero counts in the cycle after a start request, or when `running` rises.

// File: rtl/freqm_pkg.sv
package freqm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_GATE = 2'd2
  } fm_state_e;
endpackage

// File: rtl/freqm_seg.sv
module freqm_seg #(
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [SEG_W-1:0] q,
  output logic             tc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= q + 1'b1;
  end

  // carry to the next segment: enabled and at all ones
  assign tc = en & (&q);
endmodule

// File: rtl/freqm_chain.sv
module freqm_chain #(
  parameter int W     = 24,
  parameter int SEG_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam int SEGS = W / SEG_W;

  logic [SEGS:0] ce;
  assign ce[0] = en;

  // every segment shares clk; the enable ripples through terminal counts
  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    freqm_seg #(.SEG_W(SEG_W)) u_seg (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .en   (ce[g]),
      .q    (q[g*SEG_W +: SEG_W]),
      .tc   (ce[g+1])
    );
  end

  assign carry = ce[SEGS];
endmodule

// File: rtl/freqm_sync.sv
module freqm_sync #(
  parameter int   STAGES  = 2,
  parameter bit   RISING  = 1'b1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic pulse
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= {STAGES{RST_VAL}};
      prev <= RST_VAL;
    end else begin
      sh   <= {sh[STAGES-2:0], d};
      prev <= sh[STAGES-1];
    end
  end

  if (RISING) begin : g_rise
    assign pulse = sh[STAGES-1] & ~prev;
  end else begin : g_fall
    assign pulse = ~sh[STAGES-1] & prev;
  end
endmodule

// File: rtl/freqm_core.sv
module freqm_core
  import freqm_pkg::*;
#(
  parameter int REF_W  = 24,
  parameter int IN_W   = 24,
  parameter int SEG_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             sig_in,
  output logic             running,
  output logic [REF_W-1:0] ref_count,
  output logic [IN_W-1:0]  in_count,
  output logic             too_low,
  output logic             too_high
);
  // low part of (2**(REF_W+1) - 3): the value one step before the limit
  localparam logic [REF_W-1:0] LOW_PRE = {REF_W{1'b1}} - 2'd2;

  fm_state_e        state;
  logic             sig_rise, start_req;
  logic             in_gate, in_en, low_hit, close_ok;
  logic             ref_carry, in_carry, ref_hi;
  logic             too_low_q, too_high_q;
  logic [REF_W-1:0] ref_lo;
  logic [IN_W-1:0]  in_q;

  freqm_sync #(.STAGES(SYNC_N), .RISING(1'b1), .RST_VAL(1'b0)) u_sig_sync (
    .clk(clk), .rst_n(rst_n), .d(sig_in), .pulse(sig_rise)
  );

  freqm_sync #(.STAGES(SYNC_N), .RISING(1'b0), .RST_VAL(1'b1)) u_start_sync (
    .clk(clk), .rst_n(rst_n), .d(start_n), .pulse(start_req)
  );

  assign in_gate  = (state == ST_GATE);
  assign in_en    = in_gate & sig_rise;
  assign close_ok = in_gate & sig_rise & ref_hi;
  assign low_hit  = in_gate & ~sig_rise & ref_hi & (ref_lo == LOW_PRE);

  freqm_chain #(.W(REF_W), .SEG_W(SEG_W)) u_ref_chain (
    .clk(clk), .rst_n(rst_n), .clr(start_req), .en(in_gate),
    .q(ref_lo), .carry(ref_carry)
  );

  freqm_chain #(.W(IN_W), .SEG_W(SEG_W)) u_in_chain (
    .clk(clk), .rst_n(rst_n), .clr(start_req), .en(in_en),
    .q(in_q), .carry(in_carry)
  );

  // implied high bit of the reference count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ref_hi <= 1'b0;
    else if (start_req) ref_hi <= 1'b0;
    else if (ref_carry) ref_hi <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      too_low_q  <= 1'b0;
      too_high_q <= 1'b0;
    end else if (start_req) begin
      state      <= ST_ARM;
      too_low_q  <= 1'b0;
      too_high_q <= 1'b0;
    end else begin
      unique case (state)
        ST_ARM: if (sig_rise) state <= ST_GATE;
        ST_GATE: begin
          if (in_carry) begin
            state      <= ST_IDLE;
            too_high_q <= 1'b1;
          end else if (close_ok) begin
            state <= ST_IDLE;
          end else if (low_hit) begin
            state     <= ST_IDLE;
            too_low_q <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign running   = (state == ST_GATE);
  assign ref_count = ref_lo;
  assign in_count  = in_q;
  assign too_low   = too_low_q;
  assign too_high  = too_high_q;
endmodule

// File: rtl/freqm_checks.sv
module freqm_checks #(
  parameter int REF_W = 24,
  parameter int IN_W  = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             running,
  input logic [REF_W-1:0] ref_count,
  input logic [IN_W-1:0]  in_count,
  input logic             too_low,
  input logic             too_high
);
  localparam logic [REF_W-1:0] LOW_VAL = {REF_W{1'b1}} - 1'b1;

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (ref_count == '0) && (in_count == '0) && !too_low && !too_high && !running);

  assert_open_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (ref_count == '0) && (in_count == '0));

  assert_in_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && running) |-> (in_count == $past(in_count)) || (in_count == $past(in_count) + 1'b1));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(running) && !$past(clr)) |-> $stable(ref_count) && $stable(in_count));

  assert_low_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(too_low) |-> !running && (ref_count == LOW_VAL));

  assert_high_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(too_high) |-> !running && (in_count == '0));

  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(too_low && too_high));

  assert_ref_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && running) |-> (ref_count == $past(ref_count) + 1'b1));
endmodule

bind freqm_core freqm_checks #(.REF_W(REF_W), .IN_W(IN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (start_req),
  .running  (running),
  .ref_count(ref_count),
  .in_count (in_count),
  .too_low  (too_low),
  .too_high (too_high)
);

// File: tb/sim_freqm_core.sv
`timescale 1ns/1ps
module sim_freqm_core;
  localparam int RW = 8;
  localparam int IW = 4;
  localparam int LIM = (1 << (RW + 1)) - 2;

  typedef struct packed {
    logic [RW-1:0] r;
    logic [IW-1:0] i;
    logic          lo;
    logic          hi;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start_n = 1'b1, sig_in = 1'b0;
  logic running, too_low, too_high;
  logic [RW-1:0] ref_count;
  logic [IW-1:0] in_count;
  int nchk = 0, nfail = 0;
  exp_t q[$];
  logic prev_run = 1'b0;

  always #2 clk = ~clk;

  freqm_core #(.REF_W(RW), .IN_W(IW), .SEG_W(4), .SYNC_N(2)) u0 (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .sig_in(sig_in),
    .running(running), .ref_count(ref_count), .in_count(in_count),
    .too_low(too_low), .too_high(too_high)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model of one measurement with input period p cycles
  function automatic exp_t model(input int p);
    exp_t e;
    for (int j = 1; j < 4096; j++) begin
      if ((LIM - 1 >= (j - 1) * p) && (LIM - 1 <= j * p - 2)) begin
        e.r = RW'(LIM); e.i = IW'(j - 1); e.lo = 1'b1; e.hi = 1'b0;
        return e;
      end
      if (j == (1 << IW)) begin
        e.r = RW'(j * p); e.i = '0; e.lo = 1'b0; e.hi = 1'b1;
        return e;
      end
      if (j * p - 1 >= (1 << RW)) begin
        e.r = RW'(j * p); e.i = IW'(j); e.lo = 1'b0; e.hi = 1'b0;
        return e;
      end
    end
    e = '0;
    return e;
  endfunction

  function automatic string tag_of(input exp_t e);
    if (e.lo) return "R7";
    if (e.hi) return "R8";
    return "R5/R6";
  endfunction

  task automatic pulse_start();
    @(negedge clk) start_n = 1'b0;
    repeat (2) @(negedge clk);
    start_n = 1'b1;
  endtask

  task automatic drive_wave(input int p, input int nper);
    for (int k = 0; k < nper; k++) begin
      sig_in = 1'b1;
      repeat (p / 2) @(negedge clk);
      sig_in = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic run_meas(input int p);
    exp_t e;
    e = model(p);
    q.push_back(e);
    pulse_start();
    repeat (6) @(negedge clk);
    check(running == 1'b0, "R2 armed status", running, 0);
    check(ref_count == '0 && in_count == '0, "R2 cleared counts", ref_count + in_count, 0);
    drive_wave(p, 1024 / p + 3);
    repeat (8) @(negedge clk);
    check(q.size() == 0, "R5 result produced", q.size(), 0);
    // results hold after the gate ended, despite later edges
    check(ref_count == e.r, {tag_of(e), " hold ref"}, ref_count, e.r);
    check(in_count == e.i, {tag_of(e), " hold in"}, in_count, e.i);
  endtask

  // monitor: compares results when the gate closes
  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_run && running)
        check(ref_count == '0 && in_count == '0, "R3 counts zero at open", ref_count + in_count, 0);
      if (prev_run && !running && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(ref_count == e.r, {tag_of(e), " ref_count"}, ref_count, e.r);
        check(in_count == e.i, {tag_of(e), " in_count"}, in_count, e.i);
        check(too_low == e.lo, "R7 too_low flag", too_low, e.lo);
        check(too_high == e.hi, "R8 too_high flag", too_high, e.hi);
      end
      prev_run = running;
    end
  end

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!running && !too_low && !too_high, "R1 reset flags", {running, too_low, too_high}, 0);
    check(ref_count == '0 && in_count == '0, "R1 reset counts", ref_count + in_count, 0);

    run_meas(33);   // R5 R6: multi-period gate
    run_meas(100);  // R5 R6
    run_meas(18);   // R5: largest count without wrap
    run_meas(17);   // R8: wrap on the closing edge
    run_meas(7);    // R8: wrap well before close
    run_meas(510);  // R7 boundary: longest accepted gate
    run_meas(511);  // R7: one cycle too slow
    run_meas(300);  // R6: single period above threshold

    // R9 abort and R4 mid-gate counting
    pulse_start();
    repeat (6) @(negedge clk);
    drive_wave(40, 3);
    repeat (5) @(negedge clk);
    check(running == 1'b1, "R4 gate open", running, 1);
    check(in_count == 4'd2, "R4 in_count mid-gate", in_count, 2);
    pulse_start();
    repeat (6) @(negedge clk);
    check(running == 1'b0, "R9 abort drops running", running, 0);
    check(ref_count == '0 && in_count == '0, "R9 abort clears", ref_count + in_count, 0);
    repeat (40) @(negedge clk);
    check(running == 1'b0 && ref_count == '0, "R2 armed without edge", running + ref_count, 0);
    run_meas(64);   // R10: chain carries through segment boundaries

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule